// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative cache of page translations for a 64-bit core. The core uses 48-bit virtual addresses and 4 KiB pages. Each slot holds a virtual page number, a 15-bit address-space tag and a complete 64-bit page table entry. Slots with different address-space tags can hold the same virtual page at the same time, so a context switch does not need a flush. Every cycle the block searches all slots for the presented address and address-space tag. It checks the requested access against the permission bits of the matching entry, and one clock later it reports hit, fault and the entry found.

On a miss the block reports only the miss. An external walker resolves the translation and then installs it with the write command. A clear command wipes every slot. When the mode input selects no translation, every access is reported as an identity-mapped hit that may read, write and execute.

Top module: `asid_tlb`

## Requirements
- R1: A synchronous reset invalidates every slot, returns the victim pointer to slot 0, and forces `hit`, `fault` and `pteOut` to 0 after the clock edge.
- R2: The lookup result for the inputs present in one cycle appears on the outputs after the next rising edge. A hit needs both the page number `vaddr[47:12]` and `asid` to match a live slot, and `pteOut` is then that slot's stored entry.
- R3: Slots that hold the same page number under different `asid` values live side by side. Each lookup returns the entry that belongs to its own `asid`.
- R4: A slot is live only while its stored R, W and X bits (`pte[1]`, `pte[2]`, `pte[3]`) are not all zero. A write command whose data has all three bits at zero changes nothing.
- R5: `cmd` encodes 00 as no operation, 01 as write (tag taken from `vaddr` and `asid`, entry from `wrPte`), 10 as clear all, and 11 as no operation. A write or a clear takes effect at the next edge, so a lookup in the same cycle still sees the old contents.
- R6: `acc` bit 0 (read) needs R (`pte[1]`), bit 1 (write) needs W (`pte[2]`) and bit 2 (execute) needs X (`pte[3]`). On a hit, `fault` is 1 if any requested bit lacks its permission.
- R7: When `userMode` is 1, a hit on an entry whose U bit (`pte[4]`) is 0 faults.
- R8: When `userMode` is 0 and the entry's U bit is 1, an execute always faults, and a read or write faults unless `sumEn` is 1.
- R9: On a miss, `hit`, `fault` and `pteOut` are all 0.
- R10: When `mode` is 0 (bare), the result is `hit`=1 and `fault`=0. `pteOut` carries the page number in bits [45:10], bits [3:1] set, and every other bit 0. Any nonzero `mode` translates through the slots.
- R11: A write whose page number and `asid` match a live slot overwrites that slot. Otherwise it fills the lowest-numbered dead slot. If every slot is live, it overwrites the slot under the victim pointer and the pointer then steps to the next slot, wrapping after the last. A clear returns the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 2 | Command: 00 nop, 01 write, 10 clear, 11 nop |
| mode | input | 4 | Translation mode, 0 = bare |
| acc | input | 3 | Requested access: bit0 read, bit1 write, bit2 execute |
| userMode | input | 1 | 1 = user privilege, 0 = supervisor |
| sumEn | input | 1 | Supervisor may read or write user pages |
| vaddr | input | 48 | Virtual address for lookup or write tag |
| asid | input | 15 | Current address-space tag |
| wrPte | input | 64 | Page table entry to install on write |
| hit | output | 1 | Registered hit |
| fault | output | 1 | Registered permission fault (only with hit) |
| pteOut | output | 64 | Registered entry of the matching slot |

## Verification
The bench builds the block with its defaults: 8 slots, 48-bit addresses and 15-bit tags. Random traffic draws from only twelve page numbers and three address-space tags. With so few choices the buffer fills quickly, so victim wrap-around, in-place overwrites and same-page entries under different tags all come up many times. Directed phases before the random traffic cover each permission rule, bare mode, the reserved command and a write of an all-zero R/W/X entry.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  localparam int PTE_BITS = 64;
  localparam int IDX_MAX_W = 8;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_U = 4;
  localparam int PPN_LSB = 10;
  localparam logic [3:0] MODE_BARE = 4'd0;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_CLEAR = 2'b10,
    CMD_RSVD  = 2'b11
  } tlbCmd_e;

  typedef struct packed {
    logic                 wrEn;
    logic                 clrAll;
    logic [IDX_MAX_W-1:0] wrIdx;
  } tlbStrobe_t;
endpackage

// File: rtl/asid_tlb_dp.sv
module asid_tlb_dp
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 48,
  parameter int ASID_W  = 15,
  parameter int PG_W    = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  tlbStrobe_t          strb,
  input  logic [3:0]          mode,
  input  logic [2:0]          acc,
  input  logic                userMode,
  input  logic                sumEn,
  input  logic [VA_W-1:0]     vaddr,
  input  logic [ASID_W-1:0]   asid,
  input  logic [PTE_BITS-1:0] wrPte,
  output logic [ENTRIES-1:0]  matchVec,
  output logic [ENTRIES-1:0]  freeVec,
  output logic                hit,
  output logic                fault,
  output logic [PTE_BITS-1:0] pteOut
);
  localparam int VPN_W = VA_W - PG_W;

  logic [VPN_W-1:0]    tagQ  [ENTRIES];
  logic [ASID_W-1:0]   asidQ [ENTRIES];
  logic [PTE_BITS-1:0] pteQ  [ENTRIES];
  logic [VPN_W-1:0]    vpn;

  assign vpn = vaddr[VA_W-1:PG_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic live;
    assign live = |pteQ[i][BIT_X:BIT_R];
    assign matchVec[i] = live && (tagQ[i] == vpn) && (asidQ[i] == asid);
    assign freeVec[i]  = ~live;

    always_ff @(posedge clk) begin
      if (rst || strb.clrAll) begin
        tagQ[i]  <= '0;
        asidQ[i] <= '0;
        pteQ[i]  <= '0;
      end else if (strb.wrEn && strb.wrIdx == IDX_MAX_W'(i)) begin
        tagQ[i]  <= vpn;
        asidQ[i] <= asid;
        pteQ[i]  <= wrPte;
      end
    end
  end

  logic [PTE_BITS-1:0] selPte;
  logic [PTE_BITS-1:0] barePte;

  always_comb begin
    selPte = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (matchVec[i]) selPte = selPte | pteQ[i];
  end

  always_comb begin
    barePte = '0;
    barePte[PPN_LSB +: VPN_W] = vpn;
    barePte[BIT_X:BIT_R] = 3'b111;
  end

  function automatic logic permFault(logic [PTE_BITS-1:0] p, logic [2:0] a,
                                     logic u, logic s);
    logic bad;
    bad = (a[0] & ~p[BIT_R]) | (a[1] & ~p[BIT_W]) | (a[2] & ~p[BIT_X]);
    if (u) bad = bad | ~p[BIT_U];
    else if (p[BIT_U]) bad = bad | a[2] | ((a[0] | a[1]) & ~s);
    return bad;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      hit    <= 1'b0;
      fault  <= 1'b0;
      pteOut <= '0;
    end else if (mode == MODE_BARE) begin
      hit    <= 1'b1;
      fault  <= 1'b0;
      pteOut <= barePte;
    end else if (|matchVec) begin
      hit    <= 1'b1;
      fault  <= permFault(selPte, acc, userMode, sumEn);
      pteOut <= selPte;
    end else begin
      hit    <= 1'b0;
      fault  <= 1'b0;
      pteOut <= '0;
    end
  end
endmodule

// File: rtl/asid_tlb_ctrl.sv
module asid_tlb_ctrl
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cmd,
  input  logic [2:0]         wrRwx,
  input  logic [ENTRIES-1:0] matchVec,
  input  logic [ENTRIES-1:0] freeVec,
  output tlbStrobe_t         strb
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] victQ;
  logic [IDX_W-1:0] matchIdx, freeIdx, selIdx;
  logic             anyMatch, anyFree, isWr, isClr, useVict;

  assign isWr  = (tlbCmd_e'(cmd) == CMD_WRITE) && (|wrRwx);
  assign isClr = (tlbCmd_e'(cmd) == CMD_CLEAR);
  assign anyMatch = |matchVec;
  assign anyFree  = |freeVec;

  always_comb begin
    matchIdx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (matchVec[i]) matchIdx = IDX_W'(i);
  end

  always_comb begin
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (freeVec[i]) freeIdx = IDX_W'(i);
  end

  assign useVict = !anyMatch && !anyFree;
  assign selIdx  = anyMatch ? matchIdx : (anyFree ? freeIdx : victQ);

  always_ff @(posedge clk) begin
    if (rst || isClr) victQ <= '0;
    else if (isWr && useVict) victQ <= (victQ == LAST) ? '0 : victQ + 1'b1;
  end

  always_comb begin
    strb.wrEn   = isWr;
    strb.clrAll = isClr;
    strb.wrIdx  = IDX_MAX_W'(selIdx);
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 48,
  parameter int ASID_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd,
  input  logic [3:0]        mode,
  input  logic [2:0]        acc,
  input  logic              userMode,
  input  logic              sumEn,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [ASID_W-1:0] asid,
  input  logic [63:0]       wrPte,
  output logic              hit,
  output logic              fault,
  output logic [63:0]       pteOut
);
  tlbStrobe_t         strb;
  logic [ENTRIES-1:0] matchVec, freeVec;

  asid_tlb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rst(rst), .cmd(cmd), .wrRwx(wrPte[BIT_X:BIT_R]),
    .matchVec(matchVec), .freeVec(freeVec), .strb(strb)
  );

  asid_tlb_dp #(.ENTRIES(ENTRIES), .VA_W(VA_W), .ASID_W(ASID_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .mode(mode), .acc(acc),
    .userMode(userMode), .sumEn(sumEn), .vaddr(vaddr), .asid(asid),
    .wrPte(wrPte), .matchVec(matchVec), .freeVec(freeVec),
    .hit(hit), .fault(fault), .pteOut(pteOut)
  );
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  cmd,
  input logic [3:0]  mode,
  input logic [2:0]  acc,
  input logic        userMode,
  input logic        hit,
  input logic        fault,
  input logic [63:0] pteOut
);
  // R6
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> hit);

  // R9
  miss_is_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (!fault && pteOut == 64'd0));

  // R4
  hit_is_leaf_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (pteOut[3:1] != 3'b000));

  // R10
  bare_identity_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd0) |=> (hit && !fault && pteOut[3:1] == 3'b111));

  // R5
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'b10) ##1 (mode != 4'd0) |=> !hit);

  // R7
  user_needs_u_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != 4'd0 && userMode) |=> ((hit && !pteOut[4]) -> fault));

  // R8
  sup_no_exec_user_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != 4'd0 && !userMode && acc[2]) |=> ((hit && pteOut[4]) -> fault));
endmodule

bind asid_tlb asid_tlb_chk u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .mode(mode), .acc(acc),
  .userMode(userMode), .hit(hit), .fault(fault), .pteOut(pteOut)
);

// File: tb/asid_tlb_test.sv
module asid_tlb_test;
  localparam int N = 8, VA_W = 48, AW = 15, VW = 36;
  localparam logic [63:0] F_V = 64'h1, F_R = 64'h2, F_W = 64'h4, F_X = 64'h8, F_U = 64'h10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, userMode = 1'b0, sumEn = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [3:0] mode = 4'd9;
  logic [2:0] acc = 3'b001;
  logic [VA_W-1:0] vaddr = '0;
  logic [AW-1:0] asid = '0;
  logic [63:0] wrPte = '0;
  logic hit, fault;
  logic [63:0] pteOut;

  asid_tlb #(.ENTRIES(N), .VA_W(VA_W), .ASID_W(AW)) uut (
    .clk(clk), .rst(rst), .cmd(cmd), .mode(mode), .acc(acc),
    .userMode(userMode), .sumEn(sumEn), .vaddr(vaddr), .asid(asid),
    .wrPte(wrPte), .hit(hit), .fault(fault), .pteOut(pteOut)
  );

  logic [VW-1:0] mTag [N];
  logic [AW-1:0] mAsid [N];
  logic [63:0]   mPte [N];
  int mVict;
  logic eHit, eFault;
  logic [63:0] ePte;
  int nCmp = 0, nBad = 0;
  string curReq = "R1";

  function automatic bit alive(int i);
    return mPte[i][3:1] != 3'b000;
  endfunction

  function automatic int findSlot(logic [VW-1:0] v, logic [AW-1:0] a);
    for (int i = 0; i < N; i++)
      if (alive(i) && mTag[i] == v && mAsid[i] == a) return i;
    return -1;
  endfunction

  task automatic modelStep();
    logic [VW-1:0] v;
    int s;
    v = vaddr[VA_W-1:12];
    if (rst) begin
      for (int i = 0; i < N; i++) begin mTag[i] = '0; mAsid[i] = '0; mPte[i] = '0; end
      mVict = 0; eHit = 0; eFault = 0; ePte = '0;
      return;
    end
    if (mode == 4'd0) begin
      eHit = 1; eFault = 0; ePte = ({28'd0, v} << 10) | 64'hE;
    end else begin
      s = findSlot(v, asid);
      if (s < 0) begin eHit = 0; eFault = 0; ePte = '0; end
      else begin
        logic [63:0] p;
        p = mPte[s];
        eHit = 1; ePte = p; eFault = 0;
        if (acc[0] && !p[1]) eFault = 1;
        if (acc[1] && !p[2]) eFault = 1;
        if (acc[2] && !p[3]) eFault = 1;
        if (userMode && !p[4]) eFault = 1;
        if (!userMode && p[4] && acc[2]) eFault = 1;
        if (!userMode && p[4] && (acc[0] || acc[1]) && !sumEn) eFault = 1;
      end
    end
    if (cmd == 2'b10) begin
      for (int i = 0; i < N; i++) mPte[i] = '0;
      mVict = 0;
    end else if (cmd == 2'b01 && wrPte[3:1] != 3'b000) begin
      s = findSlot(v, asid);
      if (s < 0) for (int i = N - 1; i >= 0; i--) if (!alive(i)) s = i;
      if (s < 0) begin s = mVict; mVict = (mVict + 1) % N; end
      mTag[s] = v; mAsid[s] = asid; mPte[s] = wrPte;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    nCmp++;
    if (hit !== eHit || fault !== eFault || pteOut !== ePte) begin
      nBad++;
      $display("FAIL %s: hit/fault/pte got %0b/%0b/%h expected %0b/%0b/%h",
               curReq, hit, fault, pteOut, eHit, eFault, ePte);
    end
  endtask

  task automatic drive(logic [1:0] c, logic [3:0] m, logic [2:0] a, logic u, logic s,
                       logic [VW-1:0] v, logic [AW-1:0] as, logic [63:0] p);
    cmd = c; mode = m; acc = a; userMode = u; sumEn = s;
    vaddr = {v, 12'($urandom)}; asid = as; wrPte = p;
    tick();
  endtask

  task automatic wr(logic [VW-1:0] v, logic [AW-1:0] as, logic [63:0] p);
    drive(2'b01, 4'd9, 3'b001, 1'b0, 1'b0, v, as, p);
  endtask

  task automatic look(logic [VW-1:0] v, logic [AW-1:0] as, logic [2:0] a, logic u, logic s);
    drive(2'b00, 4'd9, a, u, s, v, as, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    curReq = "R1"; rst = 1; tick(); tick(); rst = 0;
    curReq = "R9"; look(36'd1, 15'd5, 3'b001, 0, 0);
    curReq = "R5"; wr(36'd1, 15'd5, (64'h123 << 10) | F_V | F_R | F_W | F_X);
    look(36'd1, 15'd5, 3'b001, 0, 0);
    curReq = "R2"; look(36'd1, 15'd5, 3'b010, 0, 0);
    curReq = "R3"; wr(36'd1, 15'd6, (64'h456 << 10) | F_V | F_R);
    look(36'd1, 15'd6, 3'b001, 0, 0); look(36'd1, 15'd5, 3'b001, 0, 0);
    look(36'd1, 15'd7, 3'b001, 0, 0);
    curReq = "R4"; wr(36'd2, 15'd5, (64'h77 << 10) | F_V | F_U);
    look(36'd2, 15'd5, 3'b001, 0, 0);
    curReq = "R5"; drive(2'b11, 4'd9, 3'b001, 0, 0, 36'd3, 15'd5, F_R | F_W);
    look(36'd3, 15'd5, 3'b001, 0, 0);
    curReq = "R6"; look(36'd1, 15'd6, 3'b010, 0, 0); look(36'd1, 15'd6, 3'b100, 0, 0);
    wr(36'd4, 15'd5, F_X | F_U);
    look(36'd4, 15'd5, 3'b100, 1, 0); look(36'd4, 15'd5, 3'b001, 1, 0);
    curReq = "R7"; look(36'd1, 15'd5, 3'b001, 1, 0);
    wr(36'd5, 15'd5, F_R | F_W | F_X | F_U);
    look(36'd5, 15'd5, 3'b010, 1, 0);
    curReq = "R8"; look(36'd5, 15'd5, 3'b001, 0, 0); look(36'd5, 15'd5, 3'b001, 0, 1);
    look(36'd5, 15'd5, 3'b010, 0, 1); look(36'd5, 15'd5, 3'b100, 0, 1);
    curReq = "R10"; drive(2'b00, 4'd0, 3'b111, 1, 0, 36'hABCDE1234, 15'd9, '0);
    drive(2'b00, 4'd3, 3'b001, 0, 0, 36'hABCDE1234, 15'd9, '0);
    curReq = "R11";
    for (int i = 0; i < 12; i++) wr(36'd20 + 36'(i), 15'd1, (64'(i) << 10) | F_R);
    wr(36'd25, 15'd1, (64'h99 << 10) | F_R | F_W);
    for (int i = 0; i < 12; i++) look(36'd20 + 36'(i), 15'd1, 3'b001, 0, 0);
    look(36'd1, 15'd5, 3'b001, 0, 0);
    curReq = "R5"; drive(2'b10, 4'd9, 3'b001, 0, 0, 36'd25, 15'd1, '0);
    look(36'd25, 15'd1, 3'b001, 0, 0);
    curReq = "R11"; for (int i = 0; i < 10; i++) wr(36'd40 + 36'(i), 15'd2, F_R);
    for (int i = 0; i < 10; i++) look(36'd40 + 36'(i), 15'd2, 3'b001, 0, 0);
    curReq = "R1"; rst = 1; tick(); rst = 0; look(36'd45, 15'd2, 3'b001, 0, 0);
    curReq = "R3";
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom_range(0, 39));
      if (k == 1500) begin rst = 1; tick(); rst = 0; end
      drive(r < 22 ? 2'b00 : r < 36 ? 2'b01 : r < 38 ? 2'b11 : 2'b10,
            ($urandom_range(0, 9) == 0) ? 4'd0 : 4'd9, 3'($urandom),
            1'($urandom), 1'($urandom), 36'($urandom_range(0, 11)),
            15'($urandom_range(0, 2)), (64'($urandom) << 10) | 64'($urandom_range(0, 31)));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule